// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the host-side master for the two-wire PHY management interface. From the host clock it makes the management clock. On a command strobe it sends one complete management frame: a run of ones as preamble, the start pattern, an opcode, the PHY and register addresses, the turnaround and sixteen data bits. On a read it gives the line to the PHY for the turnaround and the data phase, and it collects the sixteen returned bits into a read-data register. A read of PHY register 1 also updates a link-failure flag from bit 2 of the returned word.

The bidirectional data pin is formed outside the block from three signals: serial in, serial out and output enable. All frame activity is tied to a single-cycle strobe that fires in the last host cycle of each high half of the management clock, just before it falls. The outgoing frame passes through an 8-bit shift register. That register is loaded one byte at a time from the command fields, and on reads it collects the incoming bits.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: While `rst` is high and afterwards until a command is accepted, `busy`, `rd_data`, `link_fail` and `mdio_oe` are all zero.
- R2: `mdc` has a period of `CLK_DIV` host cycles (default 4) with equal high and low halves. `mdio_o` and `mdio_oe` change only in the host cycle that follows a falling edge of `mdc`.
- R3: The 64 bits after the first `mdc` fall following acceptance are sent MSB first, in this order: 32 ones, start `01`, opcode (`01` for a write, `10` for a read), the 5-bit PHY address and the 5-bit register address.
- R4: On a write, bits 46 and 47 of the frame are `1` then `0`, bits 48 to 63 are `wr_data` MSB first, and `mdio_oe` stays high for all 64 bits.
- R5: On a read, `mdio_oe` is high for frame bits 0 to 45 and low from bit 46 through bit 63.
- R6: On a read, the bit that the PHY presents after each of the last 16 `mdc` falls of the frame is taken in the host cycle just before the next fall. The result appears on `rd_data` MSB first. The high byte updates first and the low byte updates at the end of the frame. Writes leave `rd_data` unchanged.
- R7: `busy` rises in the cycle after a strobe of `cmd_valid` while idle. It stays high for exactly 64 `mdc` falls after acceptance and drops at the 65th. A strobe while `busy` is high is ignored.
- R8: At the end of a read of register address 1, `link_fail` becomes the inverse of bit 2 of the received word. Reads of other registers and all writes leave it unchanged.
- R9: `mdio_oe` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Asynchronous reset, active high |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Register address within the PHY |
| wr_data | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Data from the last read frame |
| link_fail | output | 1 | Inverse of bit 2 of the last register-1 read |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Serial data from the pad |
| mdio_o | output | 1 | Serial data to the pad |
| mdio_oe | output | 1 | Pad output enable |

## Verification
The bench sends write and read frames with extreme and alternating address and data patterns. It compares every serial bit and every output-enable value against a frame built from the command, so a swapped opcode, a byte loaded one fall early or late, or a turnaround driven on a read shows up as a bit mismatch. A small PHY model returns words whose bit 2 is set or clear. If the design latches the wrong byte first, or takes bit 2 from a shifted position, `rd_data` or `link_fail` comes out wrong. Reads of other registers and writes to register 1 catch a flag that updates too often. A strobe in mid-frame, a reset in mid-frame and a measurement of the clock period cover designs that restart a frame, keep stale state, or divide by the wrong ratio.

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int CLK_DIV  = 4,
  parameter int PREAMBLE = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic [15:0] rd_data,
  output logic        link_fail,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int CW     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LAST   = PREAMBLE + 32;
  localparam int PW     = $clog2(LAST + 2);
  localparam int P_B1   = PREAMBLE;
  localparam int P_B2   = PREAMBLE + 8;
  localparam int P_B3   = PREAMBLE + 16;
  localparam int P_B4   = PREAMBLE + 24;
  localparam int P_DRV  = PREAMBLE + 14;

  logic [CW-1:0] div_cnt;
  logic          fall_en;
  logic [PW-1:0] pos;
  logic [7:0]    sr;
  logic          q_wr;
  logic [4:0]    q_phy, q_reg;
  logic [15:0]   q_data;
  logic [7:0]    shifted;
  logic          in_pre;

  assign fall_en = mdc && (div_cnt == CW'(HALF - 1));
  assign shifted = {sr[6:0], mdio_i};
  assign in_pre  = busy && (pos >= PW'(1)) && (pos <= PW'(PREAMBLE));
  assign mdio_o  = in_pre ? 1'b1 : sr[7];
  assign mdio_oe = busy && (pos >= PW'(1)) && (q_wr || (pos <= PW'(P_DRV)));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else if (div_cnt == CW'(HALF - 1)) begin
      div_cnt <= '0;
      mdc     <= ~mdc;
    end else begin
      div_cnt <= div_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy   <= 1'b0;
      pos    <= '0;
      q_wr   <= 1'b0;
      q_phy  <= '0;
      q_reg  <= '0;
      q_data <= '0;
    end else if (!busy) begin
      if (cmd_valid) begin
        busy   <= 1'b1;
        pos    <= '0;
        q_wr   <= cmd_write;
        q_phy  <= phy_addr;
        q_reg  <= reg_addr;
        q_data <= wr_data;
      end
    end else if (fall_en) begin
      if (pos == PW'(LAST)) begin
        busy <= 1'b0;
        pos  <= '0;
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sr        <= '0;
      rd_data   <= '0;
      link_fail <= 1'b0;
    end else if (fall_en) begin
      if (busy && pos == PW'(P_B1))
        sr <= {2'b01, ~q_wr, q_wr, q_phy[4:1]};
      else if (busy && pos == PW'(P_B2))
        sr <= {q_phy[0], q_reg, 2'b10};
      else if (busy && q_wr && pos == PW'(P_B3))
        sr <= q_data[15:8];
      else if (busy && q_wr && pos == PW'(P_B4))
        sr <= q_data[7:0];
      else begin
        sr <= shifted;
        if (busy && !q_wr && pos == PW'(P_B4))
          rd_data[15:8] <= shifted;
        if (busy && !q_wr && pos == PW'(LAST)) begin
          rd_data[7:0] <= shifted;
          if (q_reg == 5'd1)
            link_fail <= ~sr[1];
        end
      end
    end
  end

  // R2
  fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fall_en |=> !mdc);
  // R2
  pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall_en |=> ($stable(mdio_o) && $stable(mdio_oe)));
  // R9
  idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall_en |=> $stable(rd_data));
  // R8
  lf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall_en |=> $stable(link_fail));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall_en) |=> busy);
endmodule

// File: tb/mdio_frame_ctrl_tb_top.sv
module mdio_frame_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy, link_fail, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  int checks = 0, errors = 0;
  logic [15:0] phy_resp = '0;
  logic got_o [64];
  logic got_oe [64];
  int falls = 0;
  logic mdc_d = 1'b0, busy_d = 1'b0;
  logic [15:0] rd_exp = '0;
  logic lf_exp = 1'b0;

  always #5 clk = ~clk;

  mdio_frame_ctrl #(.CLK_DIV(4), .PREAMBLE(32)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .rd_data(rd_data), .link_fail(link_fail), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  // PHY model and frame recorder
  always @(negedge clk) begin
    if (busy && !busy_d) begin
      falls = 0;
      mdio_i = 1'b1;
    end else if (busy && busy_d && mdc_d && !mdc) begin
      falls++;
      if (falls >= 49 && falls <= 64) mdio_i = phy_resp[15 - (falls - 49)];
      else mdio_i = 1'b1;
    end
    if (busy && !mdc_d && mdc && falls >= 1 && falls <= 64) begin
      got_o[falls-1]  = mdio_o;
      got_oe[falls-1] = mdio_oe;
    end
    mdc_d  = mdc;
    busy_d = busy;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    cmd_write = w; phy_addr = p; reg_addr = r; wr_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_frame(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [63:0] exp, act_o, act_oe, exp_oe, mask;
    exp = {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10, d};
    for (int i = 0; i < 64; i++) begin
      act_o[63-i]  = got_o[i];
      act_oe[63-i] = got_oe[i];
      exp_oe[63-i] = w ? 1'b1 : (i <= 45);
    end
    mask = w ? 64'hFFFF_FFFF_FFFF_FFFF : exp_oe;
    // R3 R4
    chk(((act_o ^ exp) & mask) == 64'd0, w ? "R4 write frame bits" : "R3 read frame bits", act_o & mask, exp & mask);
    // R5
    chk(act_oe == exp_oe, w ? "R4 write oe" : "R5 read oe", act_oe, exp_oe);
    // R7
    chk(falls == 64, "R7 falls while busy", 64'(falls), 64'd64);
  endtask

  localparam logic [26:0] VEC [7] = '{
    {1'b1, 5'h1F, 5'h00, 16'hA55A},
    {1'b0, 5'h00, 5'h1F, 16'h8001},
    {1'b1, 5'h10, 5'h01, 16'hFFFF},
    {1'b0, 5'h0A, 5'h01, 16'h0004},
    {1'b0, 5'h15, 5'h01, 16'hFFFB},
    {1'b0, 5'h03, 5'h02, 16'h1234},
    {1'b1, 5'h01, 5'h01, 16'h0000}
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({busy, rd_data, link_fail, mdio_oe} == 19'd0, "R1 reset state", {busy, rd_data, link_fail, mdio_oe}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk({busy, rd_data, link_fail, mdio_oe} == 19'd0, "R1 idle after reset", {busy, rd_data, link_fail, mdio_oe}, 0);

    // R2 clock period
    begin
      int t0, t1, c;
      c = 0;
      while (!(!mdc_d && mdc)) begin @(negedge clk); c++; end
      t0 = c;
      @(negedge clk); c++;
      while (!(!mdc_d && mdc)) begin @(negedge clk); c++; end
      t1 = c;
      chk((t1 - t0) == 4, "R2 mdc period", 64'(t1 - t0), 64'd4);
    end

    foreach (VEC[k]) begin
      logic w; logic [4:0] p, r; logic [15:0] d;
      {w, p, r, d} = VEC[k];
      phy_resp = d;
      send(w, p, r, d);
      chk(busy == 1'b1, "R7 busy after strobe", 64'(busy), 64'd1);
      wait_idle();
      check_frame(w, p, r, d);
      if (!w) begin
        rd_exp = d;
        if (r == 5'd1) lf_exp = ~d[2];
      end
      // R6
      chk(rd_data == rd_exp, "R6 read data", 64'(rd_data), 64'(rd_exp));
      // R8
      chk(link_fail == lf_exp, "R8 link flag", 64'(link_fail), 64'(lf_exp));
      // R9
      chk(mdio_oe == 1'b0, "R9 oe idle", 64'(mdio_oe), 64'd0);
    end

    // R7: strobe during a frame is ignored
    phy_resp = 16'h5A3C;
    send(1'b0, 5'h07, 5'h09, 16'h0000);
    repeat (60) @(negedge clk);
    send(1'b1, 5'h1E, 5'h1E, 16'hFFFF);
    wait_idle();
    check_frame(1'b0, 5'h07, 5'h09, 16'h0000);
    chk(rd_data == 16'h5A3C, "R6 read after ignored strobe", 64'(rd_data), 64'h5A3C);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R7 ignored strobe starts nothing", 64'(busy), 64'd0);

    // R1: reset in mid-frame clears state (link_fail currently 1)
    chk(link_fail == 1'b1, "R8 flag set before reset", 64'(link_fail), 64'd1);
    send(1'b0, 5'h02, 5'h01, 16'h0000);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk({busy, rd_data, link_fail, mdio_oe} == 19'd0, "R1 mid-frame reset", {busy, rd_data, link_fail, mdio_oe}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R1 stays idle after reset", 64'(busy), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule